// File: doc/BRIEF.md
# SD Card Initialization Sequencer

This block is the host-side controller that takes a freshly inserted SD memory card from power-on to the data transfer state. It runs through a fixed sequence of steps:

- Request a slow identification clock.
- Reset the card.
- Check the interface condition.
- Negotiate operating conditions in a retry loop.
- Read the card identity and obtain a relative address.
- Read the card-specific data and work out the capacity.
- Switch to a fast clock.
- Select the card.
- Set the block length if the card needs it.
- Move the card to a 4-bit bus.

Commands go out through a simple issue port: a command index, a 32-bit argument and a one-cycle strobe. A command engine answers each command with either a response (a 128-bit payload whose low word carries the short response) or a timeout. The sequencer asks a clock controller for a frequency change with a level request and waits for an acknowledge. When the sequence finishes, the block presents:

- the relative-address word;
- the capacity in 512-byte blocks;
- the high-capacity flag;
- a ready flag.

If the sequence fails, the block instead holds a two-bit error code.

Top module: `sdi_init_seq`

## Requirements
- R1: After a one-cycle `start` pulse in the idle state, `clk_req` rises with `clk_fast`=0 (400 kHz) and stays high until `clk_ack`. No command is issued before that acknowledge.
- R2: The first command is index 0 with argument 0, and the second is index 8 with argument 0x1AA. Every command is a single-cycle `cmd_issue` pulse, and no further command is issued until the previous one has seen `rsp_valid` or `rsp_timeout`.
- R3: A timeout on the index-8 command ends the sequence with `err_code`=1 (unsupported). A response to it whose `rsp_data[31:0]` is not 0x1AA ends the sequence with `err_code`=2 (no device).
- R4: Negotiation sends index 55 with argument 0, then index 41 with argument 0x50FF8000. The pair repeats until bit 31 of the index-41 response is 1, for at most MAX_ATTEMPTS attempts. Success on the last allowed attempt is accepted. MAX_ATTEMPTS responses with bit 31 clear give `err_code`=3 (I/O).
- R5: An index-41 response that lacks any of bits 23..15 (mask 0x00FF8000) gives `err_code`=2 at once, whatever bit 31 holds.
- R6: After negotiation, index 2 is sent with argument 0, then index 3 with argument 0. The low response word of index 3 is output on `rca_word` and is the argument of index 9, index 7 and the later index 55.
- R7: On the index-9 response, `capacity_blocks` = (C+1)·2^(M+2)·2^L/512. Here C = `rsp_data[73:62]`, M = `rsp_data[49:47]` and L = `rsp_data[83:80]`.
- R8: After the index-9 response and before index 7, `clk_req` rises with `clk_fast`=1 (25 MHz) and stays high until `clk_ack`.
- R9: Bit 30 of the accepted index-41 response drives `high_cap`. Index 16 with argument 512 is sent after index 7 only when that bit is 0.
- R10: The sequence ends with index 55 (argument `rca_word`) and then index 6 with argument 2. The response to index 6 sets `ready`=1.
- R11: A `rsp_timeout` on any command other than index 8 gives `err_code`=3. `ready` and a nonzero `err_code` both hold until reset. After either, no command or clock request is made, and `start` is ignored.
- R12: During reset, `ready`, `err_code`, `cmd_issue`, `clk_req`, `rca_word`, `capacity_blocks` and `high_cap` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the sequence (idle only) |
| clk_req | output | 1 | Clock change request, held until acknowledge |
| clk_fast | output | 1 | Requested clock: 0 = 400 kHz, 1 = 25 MHz |
| clk_ack | input | 1 | Clock controller has applied the request |
| cmd_issue | output | 1 | One-cycle command strobe |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Response for the outstanding command |
| rsp_timeout | input | 1 | No response for the outstanding command |
| rsp_data | input | 128 | Response payload, short response in [31:0] |
| ready | output | 1 | Card is in transfer state |
| err_code | output | 2 | 0 none, 1 unsupported, 2 no device, 3 I/O |
| rca_word | output | 32 | Relative address word from index 3 |
| capacity_blocks | output | 32 | Card capacity in 512-byte blocks |
| high_cap | output | 1 | High-capacity card |

## Verification
The bench builds the sequencer with MAX_ATTEMPTS=4 and keeps BLOCK_BYTES at 512. With that limit, both edges of the negotiation loop come within a few dozen cycles: a card that becomes ready on the fourth and last allowed attempt, and a card that never becomes ready and so exhausts the limit. It also runs these cases:

- a standard-capacity card with the block-length step;
- a high-capacity card without that step;
- the three early-exit error paths.

The bench checks capacity values for several field combinations of the card-specific data.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLK_SLOW, ST_GO_IDLE, ST_IF_COND,
    ST_APP_PRE, ST_OP_COND, ST_ALL_CID, ST_REL_ADDR,
    ST_READ_CSD, ST_CLK_FAST, ST_SELECT, ST_BLK_LEN,
    ST_BUS_PRE, ST_BUS_WIDTH, ST_READY, ST_FAIL
  } sdi_state_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_UNSUP = 2'd1,
    ERR_NODEV = 2'd2,
    ERR_IO    = 2'd3
  } sdi_err_e;

  localparam logic [31:0] IF_COND_ARG  = 32'h0000_01AA;
  localparam logic [31:0] OP_COND_ARG  = 32'h50FF_8000;
  localparam logic [31:0] VOLT_MASK    = 32'h00FF_8000;
  localparam logic [31:0] BUS4_ARG     = 32'h0000_0002;
  localparam int          PWRUP_BIT    = 31;
  localparam int          CCS_BIT      = 30;

endpackage

// File: rtl/sdi_attempt_ctr.sv
module sdi_attempt_ctr #(
  parameter int MAX_ATTEMPTS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last
);
  localparam int CW = (MAX_ATTEMPTS > 1) ? $clog2(MAX_ATTEMPTS) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(MAX_ATTEMPTS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear | bump;
    cnt_d  = clear ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/sdi_csd_capacity.sv
module sdi_csd_capacity #(
  parameter int BLOCK_BYTES = 512
) (
  input  logic [127:0] csd,
  output logic [31:0]  blocks
);
  localparam int BLK_SHIFT = $clog2(BLOCK_BYTES);

  logic [12:0] size_p1;
  logic [5:0]  scale;
  logic [39:0] bytes_total;
  logic [39:0] blk_wide;
  logic        unused_csd;

  always_comb begin
    size_p1     = {1'b0, csd[73:62]} + 13'd1;
    scale       = {3'b000, csd[49:47]} + 6'd2 + {2'b00, csd[83:80]};
    bytes_total = {27'd0, size_p1} << scale;
    blk_wide    = bytes_total >> BLK_SHIFT;
  end

  assign blocks     = blk_wide[31:0];
  assign unused_csd = ^{csd[127:84], csd[79:74], csd[61:50], csd[46:0], blk_wide[39:32]};
endmodule

// File: rtl/sdi_init_seq.sv
module sdi_init_seq
  import sdi_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 1000,
  parameter int BLOCK_BYTES  = 512
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         clk_req,
  output logic         clk_fast,
  input  logic         clk_ack,
  output logic         cmd_issue,
  output logic [5:0]   cmd_index,
  output logic [31:0]  cmd_arg,
  input  logic         rsp_valid,
  input  logic         rsp_timeout,
  input  logic [127:0] rsp_data,
  output logic         ready,
  output logic [1:0]   err_code,
  output logic [31:0]  rca_word,
  output logic [31:0]  capacity_blocks,
  output logic         high_cap
);
  localparam logic [31:0] BLK_LEN_ARG = 32'(BLOCK_BYTES);

  sdi_state_e state_q, state_d;
  logic       wait_q, wait_d;
  sdi_err_e   err_q, err_d;
  logic       is_cmd, rsp_evt, rsp_ok;
  logic       try_clear, try_bump, try_last;
  logic [31:0] rca_q;
  logic [31:0] cap_q, cap_calc;
  logic        hc_q;
  logic        rca_en, cap_en, hc_en;
  logic [31:0] low_word;

  assign low_word = rsp_data[31:0];

  sdi_attempt_ctr #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_try (
    .clk(clk), .rst_n(rst_n), .clear(try_clear), .bump(try_bump), .last(try_last)
  );

  sdi_csd_capacity #(.BLOCK_BYTES(BLOCK_BYTES)) u_cap (
    .csd(rsp_data), .blocks(cap_calc)
  );

  // command decode per state
  always_comb begin
    is_cmd    = 1'b1;
    cmd_index = 6'd0;
    cmd_arg   = 32'd0;
    unique case (state_q)
      ST_GO_IDLE:   cmd_index = 6'd0;
      ST_IF_COND:   begin cmd_index = 6'd8;  cmd_arg = IF_COND_ARG; end
      ST_APP_PRE:   cmd_index = 6'd55;
      ST_OP_COND:   begin cmd_index = 6'd41; cmd_arg = OP_COND_ARG; end
      ST_ALL_CID:   cmd_index = 6'd2;
      ST_REL_ADDR:  cmd_index = 6'd3;
      ST_READ_CSD:  begin cmd_index = 6'd9;  cmd_arg = rca_q; end
      ST_SELECT:    begin cmd_index = 6'd7;  cmd_arg = rca_q; end
      ST_BLK_LEN:   begin cmd_index = 6'd16; cmd_arg = BLK_LEN_ARG; end
      ST_BUS_PRE:   begin cmd_index = 6'd55; cmd_arg = rca_q; end
      ST_BUS_WIDTH: begin cmd_index = 6'd6;  cmd_arg = BUS4_ARG; end
      default:      is_cmd = 1'b0;
    endcase
  end

  assign cmd_issue = is_cmd & ~wait_q;
  assign rsp_evt   = wait_q & (rsp_valid | rsp_timeout);
  assign rsp_ok    = wait_q & rsp_valid & ~rsp_timeout;
  assign clk_req   = (state_q == ST_CLK_SLOW) | (state_q == ST_CLK_FAST);
  assign clk_fast  = (state_q == ST_CLK_FAST);

  // next-state logic
  always_comb begin
    state_d   = state_q;
    err_d     = err_q;
    try_clear = 1'b0;
    try_bump  = 1'b0;
    rca_en    = 1'b0;
    cap_en    = 1'b0;
    hc_en     = 1'b0;
    case (state_q)
      ST_IDLE:     if (start) begin state_d = ST_CLK_SLOW; try_clear = 1'b1; end
      ST_CLK_SLOW: if (clk_ack) state_d = ST_GO_IDLE;
      ST_CLK_FAST: if (clk_ack) state_d = ST_SELECT;
      ST_READY, ST_FAIL: ;
      default: begin
        if (rsp_evt && rsp_timeout) begin
          state_d = ST_FAIL;
          err_d   = (state_q == ST_IF_COND) ? ERR_UNSUP : ERR_IO;
        end else if (rsp_ok) begin
          case (state_q)
            ST_GO_IDLE: state_d = ST_IF_COND;
            ST_IF_COND:
              if (low_word != IF_COND_ARG) begin state_d = ST_FAIL; err_d = ERR_NODEV; end
              else state_d = ST_APP_PRE;
            ST_APP_PRE: state_d = ST_OP_COND;
            ST_OP_COND:
              if ((low_word & VOLT_MASK) != VOLT_MASK) begin
                state_d = ST_FAIL; err_d = ERR_NODEV;
              end else if (low_word[PWRUP_BIT]) begin
                state_d = ST_ALL_CID; hc_en = 1'b1;
              end else if (try_last) begin
                state_d = ST_FAIL; err_d = ERR_IO;
              end else begin
                state_d = ST_APP_PRE; try_bump = 1'b1;
              end
            ST_ALL_CID:   state_d = ST_REL_ADDR;
            ST_REL_ADDR:  begin state_d = ST_READ_CSD; rca_en = 1'b1; end
            ST_READ_CSD:  begin state_d = ST_CLK_FAST; cap_en = 1'b1; end
            ST_SELECT:    state_d = hc_q ? ST_BUS_PRE : ST_BLK_LEN;
            ST_BLK_LEN:   state_d = ST_BUS_PRE;
            ST_BUS_PRE:   state_d = ST_BUS_WIDTH;
            ST_BUS_WIDTH: state_d = ST_READY;
            default:      state_d = state_q;
          endcase
        end
      end
    endcase
    wait_d = (state_d != state_q) ? 1'b0 : (cmd_issue ? 1'b1 : wait_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= 1'b0;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rca_q <= '0;
    else if (rca_en) rca_q <= low_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= cap_calc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hc_q <= 1'b0;
    else if (hc_en) hc_q <= low_word[CCS_BIT];
  end

  assign ready           = (state_q == ST_READY);
  assign err_code        = err_q;
  assign rca_word        = rca_q;
  assign capacity_blocks = cap_q;
  assign high_cap        = hc_q;
endmodule

// File: rtl/sdi_init_seq_chk.sv
module sdi_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        clk_req,
  input logic        cmd_issue,
  input logic [5:0]  cmd_index,
  input logic [31:0] cmd_arg,
  input logic        ready,
  input logic [1:0]  err_code
);
  // R2
  single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |=> !cmd_issue);
  // R2
  if_cond_arg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && cmd_index == 6'd8) |-> cmd_arg == 32'h0000_01AA);
  // R4
  op_cond_arg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && cmd_index == 6'd41) |-> cmd_arg == 32'h50FF_8000);
  // R9
  blk_len_arg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && cmd_index == 6'd16) |-> cmd_arg == 32'd512);
  // R10
  bus_width_arg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && cmd_index == 6'd6) |-> cmd_arg == 32'd2);
  // R1
  clk_vs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_req && cmd_issue));
  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'd0) |=> $stable(err_code));
  // R11
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  // R11
  quiet_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready || err_code != 2'd0) |-> !(cmd_issue || clk_req));
  // R11
  excl_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && err_code != 2'd0));
  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && err_code != 2'd0) |=> !clk_req);
endmodule

bind sdi_init_seq sdi_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .clk_req(clk_req),
  .cmd_issue(cmd_issue), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
  .ready(ready), .err_code(err_code)
);

// File: tb/sdi_init_seq_bench.sv
`timescale 1ns/1ps
module sdi_init_seq_bench;
  localparam int TRIES = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, clk_ack, rsp_valid, rsp_timeout;
  logic [127:0] rsp_data;
  logic         clk_req, clk_fast, cmd_issue, ready, high_cap;
  logic [5:0]   cmd_index;
  logic [31:0]  cmd_arg, rca_word, capacity_blocks;
  logic [1:0]   err_code;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit mon_en = 1'b0;
  bit exp_ready = 1'b0;
  int exp_err = 0;

  always #2 clk = ~clk;

  sdi_init_seq #(.MAX_ATTEMPTS(TRIES), .BLOCK_BYTES(512)) u_sdi_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_req(clk_req), .clk_fast(clk_fast),
    .clk_ack(clk_ack), .cmd_issue(cmd_issue), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_data(rsp_data),
    .ready(ready), .err_code(err_code), .rca_word(rca_word),
    .capacity_blocks(capacity_blocks), .high_cap(high_cap)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic void summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endfunction

  // per-clock reference compare of the end-state outputs
  always @(posedge clk) begin
    cycles++;
    #1;
    if (mon_en) begin
      chk(ready == exp_ready, "R10", "ready per clock", longint'(ready), longint'(exp_ready));
      chk(int'(err_code) == exp_err, "R11", "err_code per clock", longint'(err_code), longint'(exp_err));
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  task automatic do_reset();
    mon_en = 1'b0;
    rst_n = 1'b0; start = 1'b0; clk_ack = 1'b0;
    rsp_valid = 1'b0; rsp_timeout = 1'b0; rsp_data = '0;
    repeat (3) @(negedge clk);
    chk({ready, err_code, cmd_issue, clk_req, high_cap} == 6'd0 && rca_word == 0
        && capacity_blocks == 0, "R12", "reset outputs",
        longint'({ready, err_code, cmd_issue, clk_req, high_cap}), 0);
    exp_ready = 1'b0; exp_err = 0;
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_clk(input bit fast, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (clk_req) begin seen = 1'b1; break; end
      chk(!cmd_issue, tag, "command before clock request", longint'(cmd_index), -1);
      @(negedge clk);
    end
    chk(seen, tag, "clock request seen", longint'(seen), 1);
    chk(clk_fast == fast, tag, "clock select", longint'(clk_fast), longint'(fast));
    repeat (2) @(negedge clk);
    chk(clk_req && !cmd_issue, tag, "request held before ack", longint'(clk_req), 1);
    clk_ack = 1'b1;
    @(negedge clk);
    clk_ack = 1'b0;
  endtask

  task automatic expect_cmd(input int idx, input logic [31:0] arg, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (cmd_issue) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk(seen, tag, "command issued", longint'(seen), 1);
    chk(int'(cmd_index) == idx, tag, "command index", longint'(cmd_index), longint'(idx));
    chk(cmd_arg == arg, tag, "command argument", longint'(cmd_arg), longint'(arg));
  endtask

  task automatic respond(input bit tmo, input logic [127:0] data,
                         input int nerr, input bit nready);
    @(negedge clk);
    chk(!cmd_issue, "R2", "single issue pulse", longint'(cmd_issue), 0);
    @(negedge clk);
    chk(!cmd_issue, "R2", "no issue while outstanding", longint'(cmd_issue), 0);
    rsp_valid = !tmo; rsp_timeout = tmo; rsp_data = data;
    exp_err = nerr; exp_ready = nready;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_timeout = 1'b0; rsp_data = '0;
  endtask

  task automatic quiet(input string tag);
    int hits = 0;
    for (int i = 0; i < 20; i++) begin
      if (cmd_issue || clk_req) hits++;
      @(negedge clk);
    end
    chk(hits == 0, tag, "activity after end", longint'(hits), 0);
  endtask

  function automatic logic [127:0] mk_csd(input int c, input int m, input int bl);
    logic [127:0] v = '0;
    v[31:0]  = 32'hDEAD_BEEF;
    v[127:126] = 2'b11;
    v[73:62] = 12'(c);
    v[49:47] = 3'(m);
    v[83:80] = 4'(bl);
    return v;
  endfunction

  function automatic longint ref_cap(input int c, input int m, input int bl);
    longint mult = longint'(1) << (m + 2);
    longint blen = longint'(1) << bl;
    return (longint'(c) + 1) * mult * blen / 512;
  endfunction

  task automatic front(input logic [31:0] echo, input bit tmo8, input int nerr8);
    pulse_start();
    expect_clk(1'b0, "R1");
    expect_cmd(0, 32'd0, "R2");
    respond(1'b0, '0, 0, 1'b0);
    expect_cmd(8, 32'h1AA, "R2");
    respond(tmo8, {96'd0, echo}, nerr8, 1'b0);
  endtask

  task automatic full_run(input bit ccs, input int c, input int m, input int bl,
                          input int not_ready, input logic [31:0] rca);
    logic [31:0] okw = 32'h80FF_8000 | (32'(ccs) << 30);
    front(32'h1AA, 1'b0, 0);
    for (int k = 0; k < not_ready; k++) begin
      expect_cmd(55, 32'd0, "R4");
      respond(1'b0, '0, 0, 1'b0);
      expect_cmd(41, 32'h50FF_8000, "R4");
      respond(1'b0, {96'd0, 32'h00FF_8000}, 0, 1'b0);
    end
    expect_cmd(55, 32'd0, "R4");
    respond(1'b0, '0, 0, 1'b0);
    expect_cmd(41, 32'h50FF_8000, "R4");
    respond(1'b0, {96'd0, okw}, 0, 1'b0);
    expect_cmd(2, 32'd0, "R6");
    respond(1'b0, {128{1'b1}} >> 1, 0, 1'b0);
    expect_cmd(3, 32'd0, "R6");
    respond(1'b0, {96'd0, rca}, 0, 1'b0);
    expect_cmd(9, rca, "R6");
    respond(1'b0, mk_csd(c, m, bl), 0, 1'b0);
    expect_clk(1'b1, "R8");
    expect_cmd(7, rca, "R6");
    respond(1'b0, '0, 0, 1'b0);
    if (!ccs) begin
      expect_cmd(16, 32'd512, "R9");
      respond(1'b0, '0, 0, 1'b0);
    end
    expect_cmd(55, rca, "R10");
    respond(1'b0, '0, 0, 1'b0);
    expect_cmd(6, 32'd2, "R10");
    respond(1'b0, '0, 0, 1'b1);
    chk(ready == 1'b1, "R10", "ready after bus width", longint'(ready), 1);
    chk(rca_word == rca, "R6", "rca_word", longint'(rca_word), longint'(rca));
    chk(longint'(capacity_blocks) == ref_cap(c, m, bl), "R7", "capacity",
        longint'(capacity_blocks), ref_cap(c, m, bl));
    chk(high_cap == ccs, "R9", "high_cap", longint'(high_cap), longint'(ccs));
    quiet("R11");
  endtask

  initial begin
    // standard capacity, ready on the last allowed attempt
    do_reset();
    full_run(1'b0, 1000, 7, 10, TRIES - 1, 32'hABCD_0000);
    // high capacity, immediate ready, smallest fields
    do_reset();
    full_run(1'b1, 0, 0, 9, 0, 32'h1234_5678);
    // large fields
    do_reset();
    full_run(1'b0, 4095, 7, 11, 1, 32'h0001_0000);

    // R3 timeout on interface condition
    do_reset();
    front(32'h0, 1'b1, 1);
    chk(err_code == 2'd1, "R3", "unsupported code", longint'(err_code), 1);
    quiet("R11");
    pulse_start();
    quiet("R11");
    chk(err_code == 2'd1, "R11", "start ignored in error", longint'(err_code), 1);

    // R3 echo mismatch
    do_reset();
    front(32'h1AB, 1'b0, 2);
    chk(err_code == 2'd2, "R3", "no-device code", longint'(err_code), 2);
    quiet("R11");

    // R5 voltage window missing a bit, power-up bit set
    do_reset();
    front(32'h1AA, 1'b0, 0);
    expect_cmd(55, 32'd0, "R4");
    respond(1'b0, '0, 0, 1'b0);
    expect_cmd(41, 32'h50FF_8000, "R4");
    respond(1'b0, {96'd0, 32'h80FF_0000}, 2, 1'b0);
    chk(err_code == 2'd2, "R5", "voltage window reject", longint'(err_code), 2);
    quiet("R11");

    // R4 never ready
    do_reset();
    front(32'h1AA, 1'b0, 0);
    for (int k = 0; k < TRIES; k++) begin
      expect_cmd(55, 32'd0, "R4");
      respond(1'b0, '0, 0, 1'b0);
      expect_cmd(41, 32'h50FF_8000, "R4");
      respond(1'b0, {96'd0, 32'h00FF_8000}, (k == TRIES - 1) ? 3 : 0, 1'b0);
    end
    chk(err_code == 2'd3, "R4", "attempt limit", longint'(err_code), 3);
    quiet("R11");

    // R11 timeout on identification
    do_reset();
    front(32'h1AA, 1'b0, 0);
    expect_cmd(55, 32'd0, "R4");
    respond(1'b0, '0, 0, 1'b0);
    expect_cmd(41, 32'h50FF_8000, "R4");
    respond(1'b0, {96'd0, 32'hC0FF_8000}, 0, 1'b0);
    expect_cmd(2, 32'd0, "R6");
    respond(1'b1, '0, 3, 1'b0);
    chk(err_code == 2'd3, "R11", "timeout gives io error", longint'(err_code), 3);
    quiet("R11");

    mon_en = 1'b0;
    summary();
    $finish;
  end
endmodule